// File: doc/BRIEF.md
# Calendar Clock With Hundredths

A binary-coded-decimal time-of-day and calendar counter. A reference-rate enable (nominally 32.768 kHz) feeds a fractional prescaler that produces exactly 100 advances per second on average. Each advance steps a chain of BCD fields: hundredths, seconds, minutes, hours, day of week, date, month and a two-digit year. Month lengths and leap years are handled. The hour can run in 24-hour form or in 12-hour form with a PM flag.

Software loads any field through a simple write port: a field select, a data byte and a strobe. Any write restarts the prescaler. The eight outputs come from a snapshot register. While the hold input is high the snapshot stays frozen, so a bus reading several bytes sees one coherent instant. Counting carries on underneath.

Top module: `rtc_calendar_core`

## Requirements
- R1: While reset is asserted, the fields read hundredths 00, seconds 00, minutes 00, hour 00 (24-hour form), day of week 01, date 01, month 01, year 00, and the prescaler is cleared.
- R2: Let n count the ref_tick cycles since reset or since the last write. The hundredths field advances in exactly those ref_tick cycles where floor(n*TICK_HZ/REF_HZ) increases. In any other cycle no field changes.
- R3: Hundredths count 00..99 and seconds and minutes count 00..59, all in packed BCD. Each wraps to 00 and carries into the next field.
- R4: Hour byte with bit6=0 is 24-hour form: bits5:0 hold BCD 00..23. Going from 23 to 00 advances the day.
- R5: Hour byte with bit6=1 is 12-hour form: bit5 is PM and bits4:0 hold BCD 01..12. The hour runs 11 to 12 with PM toggled, then 12 to 01. Only the step from 11 PM to 12 AM advances the day.
- R6: Day of week counts 1..7 and wraps from 7 to 1. It advances in the same cycle as the date.
- R7: Date wraps to 01 and advances the month after 30 in months 04, 06, 09 and 11. It does the same after 31 in months 01, 03, 05, 07, 08, 10 and 12.
- R8: In month 02 the date wraps after 29 when the BCD year is divisible by four (00 included) and after 28 otherwise.
- R9: Month wraps from 12 to 01 and advances the year. The year wraps from 99 to 00.
- R10: A write (wr_en=1) loads wr_data into the field chosen by wr_sel (0 hundredths, 1 seconds, 2 minutes, 3 hour, 4 day of week, 5 date, 6 month, 7 year) at the next clock edge. It clears the prescaler, and no field advances in that cycle.
- R11: At a clock edge where hold is high, the outputs keep their values. At a clock edge where hold is low, the outputs take the live field values produced at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle enable at the reference rate |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field select for a write |
| wr_data | input | 8 | BCD value to load |
| hold | input | 1 | Freeze the visible snapshot |
| hsec_o | output | 8 | Hundredths, BCD |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hour byte with mode and PM bits |
| dow_o | output | 8 | Day of week, BCD 1..7 |
| date_o | output | 8 | Date, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year, BCD |

## Verification
A write and a prescaler advance can fall in the same cycle. The bench provokes this by driving three reference enables after a load, so the fourth would carry, and then presenting that fourth enable together with a write. The check is that only the written field changes and that a full fresh prescaler period is then needed before the hundredths move. Hold overlapping a roll-over is also exercised: the frozen outputs must stay put, and the release must show the advanced values.

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core #(
  parameter int REF_HZ  = 32768,
  parameter int TICK_HZ = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic       hold,
  output logic [7:0] hsec_o,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o
);
  localparam int AW = $clog2(REF_HZ + TICK_HZ) + 1;
  localparam logic [AW-1:0] REF_W  = AW'(REF_HZ);
  localparam logic [AW-1:0] STEP_W = AW'(TICK_HZ);

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  logic [AW-1:0] acc;
  logic [7:0] hs, sc, mn, hr, dw, dt, mo, yr;
  logic [7:0] n_hs, n_sc, n_mn, n_hr, n_dw, n_dt, n_mo, n_yr;

  wire [AW-1:0] acc_sum = acc + STEP_W;
  wire tick = ref_tick && !wr_en && (acc_sum >= REF_W);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          acc <= '0;
    else if (wr_en)      acc <= '0;
    else if (ref_tick)   acc <= tick ? acc_sum - REF_W : acc_sum;

  wire mode12 = hr[6];
  wire pm     = hr[5];
  wire [7:0] hr12_inc = bcd_inc({3'b000, hr[4:0]});

  wire c_sec = tick && (hs == 8'h99);
  wire c_min = c_sec && (sc == 8'h59);
  wire c_hr  = c_min && (mn == 8'h59);
  wire day_wrap = mode12 ? (hr[4:0] == 5'h11 && pm) : (hr[5:0] == 6'h23);
  wire c_day = c_hr && day_wrap;

  wire leap = yr[4] ? (yr[3:0] == 4'd2 || yr[3:0] == 4'd6)
                    : (yr[3:0] == 4'd0 || yr[3:0] == 4'd4 || yr[3:0] == 4'd8);
  logic [7:0] last_day;
  always_comb
    case (mo)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase

  wire c_mon = c_day && (dt == last_day);
  wire c_yr  = c_mon && (mo == 8'h12);

  logic [7:0] hr_step;
  always_comb
    if (mode12) begin
      if (hr[4:0] == 5'h11)      hr_step = {2'b01, ~pm, 5'h12};
      else if (hr[4:0] == 5'h12) hr_step = {2'b01, pm, 5'h01};
      else                       hr_step = {hr[7:5], hr12_inc[4:0]};
    end else begin
      hr_step = (hr[5:0] == 6'h23) ? 8'h00 : bcd_inc(hr);
    end

  always_comb begin
    n_hs = hs; n_sc = sc; n_mn = mn; n_hr = hr;
    n_dw = dw; n_dt = dt; n_mo = mo; n_yr = yr;
    if (wr_en) begin
      case (wr_sel)
        3'd0: n_hs = wr_data;
        3'd1: n_sc = wr_data;
        3'd2: n_mn = wr_data;
        3'd3: n_hr = wr_data;
        3'd4: n_dw = wr_data;
        3'd5: n_dt = wr_data;
        3'd6: n_mo = wr_data;
        default: n_yr = wr_data;
      endcase
    end else begin
      if (tick)  n_hs = (hs == 8'h99) ? 8'h00 : bcd_inc(hs);
      if (c_sec) n_sc = (sc == 8'h59) ? 8'h00 : bcd_inc(sc);
      if (c_min) n_mn = (mn == 8'h59) ? 8'h00 : bcd_inc(mn);
      if (c_hr)  n_hr = hr_step;
      if (c_day) begin
        n_dw = (dw == 8'h07) ? 8'h01 : bcd_inc(dw);
        n_dt = (dt == last_day) ? 8'h01 : bcd_inc(dt);
      end
      if (c_mon) n_mo = (mo == 8'h12) ? 8'h01 : bcd_inc(mo);
      if (c_yr)  n_yr = (yr == 8'h99) ? 8'h00 : bcd_inc(yr);
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hs <= 8'h00; sc <= 8'h00; mn <= 8'h00; hr <= 8'h00;
      dw <= 8'h01; dt <= 8'h01; mo <= 8'h01; yr <= 8'h00;
    end else begin
      hs <= n_hs; sc <= n_sc; mn <= n_mn; hr <= n_hr;
      dw <= n_dw; dt <= n_dt; mo <= n_mo; yr <= n_yr;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hsec_o <= 8'h00; sec_o <= 8'h00; min_o <= 8'h00; hour_o <= 8'h00;
      dow_o <= 8'h01; date_o <= 8'h01; month_o <= 8'h01; year_o <= 8'h00;
    end else if (!hold) begin
      hsec_o <= n_hs; sec_o <= n_sc; min_o <= n_mn; hour_o <= n_hr;
      dow_o <= n_dw; date_o <= n_dt; month_o <= n_mo; year_o <= n_yr;
    end

  p_prescale_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc < REF_W);
  p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !tick) |=> ($stable(hs) && $stable(sc) && $stable(mn) && $stable(hr)
                          && $stable(dt) && $stable(mo) && $stable(yr)));
  p_hsec_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hs == 8'h99) |=> (hs == 8'h00));
  p_year_roll_r9: assert property (@(posedge clk) disable iff (!rst_n)
    c_yr |=> (mo == 8'h01 && dt == 8'h01));
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (acc == '0));
  p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd2) |=> (mn == $past(wr_data)));
  p_hold_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(hsec_o) && $stable(sec_o) && $stable(hour_o) && $stable(date_o)));
endmodule

// File: tb/tb_rtc_calendar_core.sv
module tb_rtc_calendar_core;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, ref_tick = 1'b0, wr_en = 1'b0, hold = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] hsec_o, sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;

  rtc_calendar_core #(.REF_HZ(10), .TICK_HZ(3)) dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .hold(hold), .hsec_o(hsec_o), .sec_o(sec_o), .min_o(min_o),
    .hour_o(hour_o), .dow_o(dow_o), .date_o(date_o), .month_o(month_o), .year_o(year_o));

  int n_cmp = 0, n_bad = 0;
  int m_hs = 0, m_sc = 0, m_mn = 0, m_h = 0, m_dw = 1, m_dt = 1, m_mo = 1, m_yr = 0;
  bit m12 = 0, mpm = 0, advanced = 0;
  int nref = 0;
  logic [7:0] expv [8];

  function automatic logic [7:0] to_bcd(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction
  function automatic int from_bcd(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic int mdays(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction
  function automatic logic [7:0] enc(int f);
    logic [7:0] h;
    case (f)
      0: return to_bcd(m_hs);
      1: return to_bcd(m_sc);
      2: return to_bcd(m_mn);
      3: begin h = to_bcd(m_h); return m12 ? {2'b01, mpm, h[4:0]} : h; end
      4: return to_bcd(m_dw);
      5: return to_bcd(m_dt);
      6: return to_bcd(m_mo);
      default: return to_bcd(m_yr);
    endcase
  endfunction

  function automatic void m_write(logic [2:0] s, logic [7:0] d);
    case (s)
      3'd0: m_hs = from_bcd(d);
      3'd1: m_sc = from_bcd(d);
      3'd2: m_mn = from_bcd(d);
      3'd3: begin
        m12 = d[6];
        if (d[6]) begin mpm = d[5]; m_h = from_bcd({3'b000, d[4:0]}); end
        else begin mpm = 0; m_h = from_bcd({2'b00, d[5:0]}); end
      end
      3'd4: m_dw = from_bcd(d);
      3'd5: m_dt = from_bcd(d);
      3'd6: m_mo = from_bcd(d);
      default: m_yr = from_bcd(d);
    endcase
  endfunction

  function automatic void m_advance();
    bit day = 0;
    m_hs++;
    if (m_hs < 100) return;
    m_hs = 0; m_sc++;
    if (m_sc < 60) return;
    m_sc = 0; m_mn++;
    if (m_mn < 60) return;
    m_mn = 0;
    if (m12) begin
      if (m_h == 11) begin m_h = 12; mpm = !mpm; day = !mpm; end
      else if (m_h == 12) m_h = 1;
      else m_h++;
    end else begin
      m_h++;
      if (m_h == 24) begin m_h = 0; day = 1; end
    end
    if (!day) return;
    m_dw = (m_dw == 7) ? 1 : m_dw + 1;
    m_dt++;
    if (m_dt <= mdays(m_mo, m_yr)) return;
    m_dt = 1; m_mo++;
    if (m_mo <= 12) return;
    m_mo = 1; m_yr = (m_yr + 1) % 100;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit r, bit w, logic [2:0] s, logic [7:0] d, bit h);
    @(negedge clk);
    ref_tick = r; wr_en = w; wr_sel = s; wr_data = d; hold = h;
    advanced = 0;
    if (w) begin m_write(s, d); nref = 0; end
    else if (r) begin
      nref++;
      if ((nref * 3) / 10 != ((nref - 1) * 3) / 10) begin m_advance(); advanced = 1; end
    end
    if (!h) for (int f = 0; f < 8; f++) expv[f] = enc(f);
    @(posedge clk); #1;
    chk("R2 R3 R10 R11 hsec", hsec_o, expv[0]);
    chk("R3 sec", sec_o, expv[1]);
    chk("R3 min", min_o, expv[2]);
    chk("R4 R5 hour", hour_o, expv[3]);
    chk("R6 dow", dow_o, expv[4]);
    chk("R7 R8 date", date_o, expv[5]);
    chk("R9 month", month_o, expv[6]);
    chk("R9 year", year_o, expv[7]);
  endtask

  task automatic load(logic [7:0] a0, a1, a2, a3, a4, a5, a6, a7);
    step(0, 1, 3'd0, a0, 0); step(0, 1, 3'd1, a1, 0);
    step(0, 1, 3'd2, a2, 0); step(0, 1, 3'd3, a3, 0);
    step(0, 1, 3'd4, a4, 0); step(0, 1, 3'd5, a5, 0);
    step(0, 1, 3'd6, a6, 0); step(0, 1, 3'd7, a7, 0);
  endtask

  task automatic tick_one();
    for (int i = 0; i < 12; i++) begin
      step(1, 0, 3'd0, 8'h00, 0);
      if (advanced) break;
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired (all requirements)");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic [2:0] s;
    void'($urandom(32'd4711));
    for (int f = 0; f < 8; f++) expv[f] = enc(f);
    repeat (3) @(posedge clk);
    #1;
    chk("R1 hsec", hsec_o, 8'h00); chk("R1 hour", hour_o, 8'h00);
    chk("R1 dow", dow_o, 8'h01);   chk("R1 date", date_o, 8'h01);
    chk("R1 month", month_o, 8'h01); chk("R1 year", year_o, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    // R2: from reset the fourth reference enable advances hundredths, gaps change nothing
    step(1, 0, 0, 0, 0); step(0, 0, 0, 0, 0); step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0);
    chk("R2 no advance yet", hsec_o, 8'h00);
    step(1, 0, 0, 0, 0);
    chk("R2 fourth enable", hsec_o, 8'h01);

    // R3 R4 R6 R9: full roll-over at year end
    load(8'h99, 8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    tick_one();
    chk("R3 hsec wrap", hsec_o, 8'h00); chk("R3 sec wrap", sec_o, 8'h00);
    chk("R3 min wrap", min_o, 8'h00);   chk("R4 hour 23->00", hour_o, 8'h00);
    chk("R6 dow 7->1", dow_o, 8'h01);   chk("R9 date", date_o, 8'h01);
    chk("R9 month 12->01", month_o, 8'h01); chk("R9 year 99->00", year_o, 8'h00);

    // R8: February
    load(8'h99, 8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23);
    tick_one();
    chk("R8 non-leap date", date_o, 8'h01); chk("R8 non-leap month", month_o, 8'h03);
    load(8'h99, 8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
    tick_one();
    chk("R8 leap 29th", date_o, 8'h29); chk("R8 leap month", month_o, 8'h02);
    load(8'h99, 8'h59, 8'h59, 8'h23, 8'h03, 8'h29, 8'h02, 8'h00);
    tick_one();
    chk("R8 year 00 end", date_o, 8'h01); chk("R8 year 00 month", month_o, 8'h03);

    // R7: 30- and 31-day months
    load(8'h99, 8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h10);
    tick_one();
    chk("R7 april end", date_o, 8'h01); chk("R7 april month", month_o, 8'h05);
    load(8'h99, 8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h10, 8'h10);
    tick_one();
    chk("R7 october 31st", date_o, 8'h31); chk("R7 october month", month_o, 8'h10);
    load(8'h99, 8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h11, 8'h10);
    tick_one();
    chk("R7 november end", month_o, 8'h12);

    // R5: 12-hour sequence
    load(8'h99, 8'h59, 8'h59, 8'h51, 8'h02, 8'h10, 8'h05, 8'h10);
    tick_one();
    chk("R5 11AM->12PM", hour_o, 8'h72); chk("R5 no day advance", date_o, 8'h10);
    load(8'h99, 8'h59, 8'h59, 8'h72, 8'h02, 8'h10, 8'h05, 8'h10);
    tick_one();
    chk("R5 12PM->01PM", hour_o, 8'h61);
    load(8'h99, 8'h59, 8'h59, 8'h71, 8'h02, 8'h10, 8'h05, 8'h10);
    tick_one();
    chk("R5 11PM->12AM", hour_o, 8'h52); chk("R5 day advance", date_o, 8'h11);
    chk("R6 dow with date", dow_o, 8'h03);

    // R10: write collides with a due advance
    load(8'h40, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0);
    step(1, 1, 3'd2, 8'h17, 0);
    chk("R10 advance suppressed", hsec_o, 8'h40); chk("R10 written", min_o, 8'h17);
    step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0);
    chk("R10 prescaler restarted", hsec_o, 8'h40);
    step(1, 0, 0, 0, 0);
    chk("R10 first advance after write", hsec_o, 8'h41);

    // R11: hold across a roll-over
    load(8'h98, 8'h59, 8'h12, 8'h08, 8'h01, 8'h05, 8'h06, 8'h30);
    for (int i = 0; i < 12; i++) step(1, 0, 0, 0, 1);
    chk("R11 frozen hsec", hsec_o, 8'h98); chk("R11 frozen sec", sec_o, 8'h59);
    step(0, 0, 0, 0, 0);
    chk("R11 release hsec", hsec_o, 8'h01); chk("R11 release min", min_o, 8'h13);

    // random mix of enables, holds and valid writes
    for (int i = 0; i < 6000; i++) begin
      s = 3'($urandom_range(0, 7));
      case (s)
        3'd0: d = to_bcd($urandom_range(0, 99));
        3'd1, 3'd2: d = to_bcd($urandom_range(55, 59));
        3'd3: if ($urandom_range(0, 1)) begin
                d = to_bcd($urandom_range(10, 12));
                d = {2'b01, 1'($urandom_range(0, 1)), d[4:0]};
              end else d = to_bcd($urandom_range(20, 23));
        3'd4: d = to_bcd($urandom_range(1, 7));
        3'd5: d = to_bcd($urandom_range(1, 28));
        3'd6: d = to_bcd($urandom_range(1, 12));
        default: d = to_bcd($urandom_range(0, 99));
      endcase
      step(1'($urandom_range(0, 9) < 8), 1'($urandom_range(0, 99) < 2), s, d,
           1'($urandom_range(0, 9) == 0));
    end
    finish_run();
  end
endmodule